// File: doc/BRIEF.md
# Infrared Run-Length Transmitter

This block drives a consumer-infrared emitter from a queue of run-length codes. Control logic writes one byte at a time into a 32-entry transmit queue. Bit 7 of each byte chooses a burst of modulated carrier or a quiet gap. Bits 6:0 give the length of that burst or gap in bit periods. Once transmission is enabled, the block pops codes one after another with no idle cycle between them. During a burst it gates a square-wave carrier onto the emitter output. During a gap it holds the output low.

The carrier comes from a counter with a programmable period, in system clocks. A 3-bit width code sets how long the carrier stays high within each period. The length of one bit period is a build-time parameter. Software can read the queue occupancy, empty the queue at once, and enable a level-sensitive refill interrupt. That interrupt asserts while the occupancy is at or below one of four selectable levels.

Top module: `ir_rle_tx`

## Requirements
- R1: The queue holds up to 32 bytes. `fifo_count` reports the number of occupied entries, from 0 to 32. A write made while the queue holds 32 entries is discarded.
- R2: A byte with bit 7 = 0 is a burst: `ir_out` follows the carrier for the whole run. A byte with bit 7 = 1 is a gap: `ir_out` stays low for the whole run.
- R3: With `rle_en` = 1, a byte lasts (bits 6:0 + 1) × BIT_CLKS clocks, so field 0x7F lasts 128 bit periods. With `rle_en` = 0, every byte lasts exactly one bit period.
- R4: The carrier period is `car_period` clocks. In each period the carrier is high for the first (car_period × (pw_code + 1)) / 8 clocks, rounded down. Its phase is 0 in the first cycle after transmission starts from idle, and it runs on without restarting across back-to-back runs.
- R5: `thr_sel` codes 0, 1, 2 and 3 select low levels of 1, 7, 17 and 25 entries. `irq` is high exactly when `fifo_count` ≤ the selected level, `tx_enable` = 1, and both enables of R6 are set.
- R6: `irq` is low whenever `irq_en` = 0 or `glb_irq_en` = 0.
- R7: A `fifo_clr` pulse leaves `fifo_count` at 0 after the next clock edge. A write in the same cycle is discarded. A run already in progress completes.
- R8: `busy` rises in the first cycle of the first run and stays high through consecutive runs. It falls in the cycle after the last run's final clock. While `busy` is low, `ir_out` is low.
- R9: After reset the queue is empty, `busy` = 0 and `ir_out` = 0.
- R10: While `tx_enable` = 0, no new run starts: queued bytes stay queued, `busy` stays low and `ir_out` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Push `wr_data` into the queue |
| wr_data | input | 8 | Run-length code: bit 7 gap/burst, bits 6:0 length |
| fifo_clr | input | 1 | Empty the queue |
| tx_enable | input | 1 | Allow runs to start |
| rle_en | input | 1 | Use the length field (1) or a single bit period (0) |
| thr_sel | input | 2 | Low-level select: 1, 7, 17, 25 entries |
| irq_en | input | 1 | Refill interrupt enable |
| glb_irq_en | input | 1 | Global interrupt enable |
| car_period | input | 8 | Carrier period in clocks |
| pw_code | input | 3 | Carrier high time in eighths of a period, minus one |
| ir_out | output | 1 | Modulated emitter drive |
| busy | output | 1 | A run is in progress |
| fifo_count | output | 6 | Occupied queue entries |
| irq | output | 1 | Refill interrupt, level-sensitive |

## Verification
The bench compares `ir_out` cycle by cycle against a model of random code sequences with random carrier settings. A design that restarted the carrier phase on each run, or that left a gap cycle between runs, would diverge at the first run boundary. It also checks the maximum length field 0x7F, with and without run-length mode. A design that dropped a bit or counted one period too few would lower `busy` at the wrong clock. The bench probes each threshold exactly at its level and one entry above it, where a strict comparison would miss by one. Finally it covers overfilling, clearing during a write, and clearing in the middle of a burst. A design that cut the current run short, or counted a rejected write, would show the wrong `busy` edge or the wrong count.

// File: rtl/ir_tx_pkg.sv
// Shared types and helpers for the infrared run-length transmitter.
// Assumes the queue depth is at least the highest low level (25).
package ir_tx_pkg;

    // One queued code: gap flag over a 7-bit length field.
    typedef struct packed {
        logic       space;
        logic [6:0] len;
    } rle_code_t;

    // Map the 2-bit threshold code onto its low-data level.
    function automatic int unsigned low_level(input logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 7;
            2'd2:    return 17;
            default: return 25;
        endcase
    endfunction

endpackage

// File: rtl/ir_tx_fifo.sv
// Byte queue for run-length codes with an occupancy count and a clear.
// Assumes DEPTH is a power of two, so the pointers wrap naturally.
// Clear beats a write in the same cycle; a write into a full queue is lost.
module ir_tx_fifo #(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [7:0]    din,
    input  logic          pop,
    input  logic          clr,
    output logic [7:0]    dout,
    output logic [CW-1:0] count,
    output logic          empty
);
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign do_push = push && !clr && (count < CW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    assert_push_counts_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr && !pop && count < CW'(DEPTH)) |=> (count == $past(count) + CW'(1)));
    assert_full_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !clr && count == CW'(DEPTH)) |=> (count == CW'(DEPTH)));
    assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));
endmodule

// File: rtl/ir_carrier_gen.sv
// Carrier source: counts clocks modulo the programmed period while running
// and is high for the first (period*(pw+1))/8 clocks of each period.
// Phase is held at zero while not running.
module ir_carrier_gen #(
    parameter int CPW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [CPW-1:0] period,
    input  logic [2:0]     pw,
    output logic           hi
);
    logic [CPW-1:0] cnt;
    logic [CPW+3:0] prod;
    logic [CPW:0]   on_cnt;

    assign prod   = {4'b0, period} * {{CPW{1'b0}}, ({1'b0, pw} + 4'd1)};
    assign on_cnt = prod[CPW+3:3];
    assign hi     = run && ({1'b0, cnt} < on_cnt);

    // Phase counter, free-running modulo the period during a transmission.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)              cnt <= '0;
        else if (cnt >= period - CPW'(1)) cnt <= '0;
        else                              cnt <= cnt + CPW'(1);
    end

    assert_phase_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && period != '0) |-> (cnt < period));
    assert_phase_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));
endmodule

// File: rtl/ir_run_engine.sv
// Run sequencer: takes the queue head when idle or when the current run ends
// on its last bit-period clock, so runs follow each other without a gap.
// Assumes BIT_CLKS >= 1; the queue head is valid whenever empty is low.
module ir_run_engine #(
    parameter int BIT_CLKS = 16,
    parameter int BCW      = $clog2(BIT_CLKS + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_enable,
    input  logic       rle_en,
    input  logic       fifo_empty,
    input  logic [7:0] head,
    output logic       pop,
    output logic       active,
    output logic       is_space
);
    import ir_tx_pkg::*;

    rle_code_t      code;
    logic [6:0]     left;
    logic [BCW-1:0] bit_cnt;
    logic           period_end, finishing;

    assign code       = rle_code_t'(head);
    assign period_end = (bit_cnt == BCW'(BIT_CLKS - 1));
    assign finishing  = active && period_end && (left == '0);
    assign pop        = tx_enable && !fifo_empty && (!active || finishing);

    // Load, count down and retire runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            is_space <= 1'b0;
            left     <= '0;
            bit_cnt  <= '0;
        end else if (pop) begin
            active   <= 1'b1;
            is_space <= code.space;
            left     <= rle_en ? code.len : 7'd0;
            bit_cnt  <= '0;
        end else if (finishing) begin
            active   <= 1'b0;
            bit_cnt  <= '0;
        end else if (active) begin
            if (period_end) begin
                bit_cnt <= '0;
                left    <= left - 7'd1;
            end else begin
                bit_cnt <= bit_cnt + BCW'(1);
            end
        end
    end

    assert_level_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !pop) |=> $stable(is_space));
    assert_no_start_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !tx_enable) |=> !active);
    assert_gapless_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (finishing && tx_enable && !fifo_empty) |=> active);
endmodule

// File: rtl/ir_rle_tx.sv
// Top level of the infrared run-length transmitter: queue, run sequencer,
// carrier source and a level-sensitive refill interrupt.
// Assumes DEPTH >= 25 so every low level is reachable.
module ir_rle_tx #(
    parameter int DEPTH    = 32,
    parameter int BIT_CLKS = 16,
    parameter int CPW      = 8,
    parameter int CW       = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          fifo_clr,
    input  logic          tx_enable,
    input  logic          rle_en,
    input  logic [1:0]    thr_sel,
    input  logic          irq_en,
    input  logic          glb_irq_en,
    input  logic [CPW-1:0] car_period,
    input  logic [2:0]    pw_code,
    output logic          ir_out,
    output logic          busy,
    output logic [CW-1:0] fifo_count,
    output logic          irq
);
    localparam int AW = $clog2(DEPTH);

    logic [7:0]    head;
    logic          empty, pop, active, is_space, car_hi;
    logic [CW-1:0] level;

    ir_tx_fifo #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(wr_en), .din(wr_data), .pop(pop),
        .clr(fifo_clr), .dout(head), .count(fifo_count), .empty(empty)
    );

    ir_run_engine #(.BIT_CLKS(BIT_CLKS)) u_engine (
        .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .rle_en(rle_en),
        .fifo_empty(empty), .head(head), .pop(pop), .active(active),
        .is_space(is_space)
    );

    ir_carrier_gen #(.CPW(CPW)) u_carrier (
        .clk(clk), .rst_n(rst_n), .run(active), .period(car_period),
        .pw(pw_code), .hi(car_hi)
    );

    // Output gating and interrupt level.
    assign level  = CW'(ir_tx_pkg::low_level(thr_sel));
    assign busy   = active;
    assign ir_out = active && !is_space && car_hi;
    assign irq    = irq_en && glb_irq_en && tx_enable && (fifo_count <= level);

    assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en && glb_irq_en));
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ir_out);
    assert_irq_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && glb_irq_en && tx_enable && fifo_count > CW'(25)) |-> !irq);
endmodule

// File: tb/ir_rle_tx_test.sv
// Self-checking bench: fixed-seed random run sequences plus directed corners.
module ir_rle_tx_test;
    localparam int BC = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       fifo_clr = 1'b0;
    logic       tx_enable = 1'b0;
    logic       rle_en = 1'b1;
    logic [1:0] thr_sel = 2'd2;
    logic       irq_en = 1'b1;
    logic       glb_irq_en = 1'b1;
    logic [7:0] car_period = 8'd8;
    logic [2:0] pw_code = 3'd4;
    logic       ir_out, busy, irq;
    logic [5:0] fifo_count;

    int checks = 0;
    int fails  = 0;
    logic [7:0] seq [0:39];
    int nseq;

    ir_rle_tx #(.DEPTH(32), .BIT_CLKS(BC), .CPW(8)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .fifo_clr(fifo_clr), .tx_enable(tx_enable), .rle_en(rle_en),
        .thr_sel(thr_sel), .irq_en(irq_en), .glb_irq_en(glb_irq_en),
        .car_period(car_period), .pw_code(pw_code), .ir_out(ir_out),
        .busy(busy), .fifo_count(fifo_count), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int run_len(input logic [7:0] b, input bit rle);
        return rle ? (int'(b[6:0]) + 1) * BC : BC;
    endfunction

    function automatic int total_len(input bit rle);
        int s = 0;
        for (int k = 0; k < nseq; k++) s += run_len(seq[k], rle);
        return s;
    endfunction

    // Expected emitter level t cycles after the first run started.
    function automatic bit exp_out(input int t, input bit rle, input int per, input int pw);
        int acc = 0;
        int on  = (per * (pw + 1)) / 8;
        for (int k = 0; k < nseq; k++) begin
            acc += run_len(seq[k], rle);
            if (t < acc) return !seq[k][7] && ((t % per) < on);
        end
        return 1'b0;
    endfunction

    // All tasks start and end just after a falling edge.
    task automatic push(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clear_q();
        fifo_clr = 1'b1;
        @(negedge clk);
        fifo_clr = 1'b0;
    endtask

    // Queue a sequence with transmission held off, then play and compare it.
    task automatic play(input bit rle, input int per, input int pw);
        int tot, bad, bad_t;
        bit seen;
        rle_en = rle; car_period = 8'(per); pw_code = 3'(pw);
        clear_q();
        for (int k = 0; k < nseq; k++) push(seq[k]);
        seen = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (busy || ir_out) seen = 1'b1;
        end
        chk(!seen, "R10 held sequence stays idle", int'(seen), 0);
        chk(fifo_count == 6'(nseq), "R10 bytes stay queued", fifo_count, nseq);
        tot = total_len(rle);
        bad = 0; bad_t = -1;
        tx_enable = 1'b1;
        @(posedge clk);
        for (int t = 0; t <= tot; t++) begin
            @(negedge clk);
            if (t == 0) chk(fifo_count == 6'(nseq - 1), "R1 count after first pop", fifo_count, nseq - 1);
            if (t < tot && ir_out !== exp_out(t, rle, per, pw)) begin
                bad++;
                if (bad_t < 0) bad_t = t;
            end
            if (t == tot - 1) chk(busy === 1'b1, "R3 busy through last clock", int'(busy), 1);
            if (t == tot) chk(busy === 1'b0, "R8 busy falls after last run", int'(busy), 0);
        end
        chk(bad == 0, "R2 R4 emitter trace (first bad cycle as actual)", bad_t, -1);
        tx_enable = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(fifo_count == 0, "R9 count after reset", fifo_count, 0);
        chk(busy == 0, "R9 busy after reset", int'(busy), 0);
        chk(ir_out == 0, "R9 output after reset", int'(ir_out), 0);
        chk(irq == 0, "R5 irq low with transmit disabled", int'(irq), 0);

        // R6 enable gating, queue empty and transmit enabled between edges
        tx_enable = 1'b1; #1;
        chk(irq == 1, "R5 irq empty queue", int'(irq), 1);
        irq_en = 1'b0; #1;
        chk(irq == 0, "R6 irq_en clear", int'(irq), 0);
        irq_en = 1'b1; glb_irq_en = 1'b0; #1;
        chk(irq == 0, "R6 global enable clear", int'(irq), 0);
        glb_irq_en = 1'b1; tx_enable = 1'b0;
        @(negedge clk);

        // R5 each threshold at its level and one above
        for (int c = 0; c < 4; c++) begin
            int lvl;
            lvl = (c == 0) ? 1 : (c == 1) ? 7 : (c == 2) ? 17 : 25;
            thr_sel = 2'(c);
            clear_q();
            for (int k = 0; k < lvl; k++) push(8'h81);
            tx_enable = 1'b1; #1;
            chk(irq == 1, "R5 irq at threshold", int'(irq), 1);
            tx_enable = 1'b0;
            push(8'h81);
            tx_enable = 1'b1; #1;
            chk(irq == 0, "R5 irq above threshold", int'(irq), 0);
            tx_enable = 1'b0;
            @(negedge clk);
        end

        // R1 overfill, then R7 clear with a simultaneous write
        clear_q();
        for (int k = 0; k < 34; k++) push(8'(k));
        chk(fifo_count == 32, "R1 count saturates at 32", fifo_count, 32);
        fifo_clr = 1'b1; wr_en = 1'b1; wr_data = 8'h11;
        @(negedge clk);
        fifo_clr = 1'b0; wr_en = 1'b0;
        chk(fifo_count == 0, "R7 clear beats write", fifo_count, 0);

        // R3 longest field, with and without run-length mode
        nseq = 2; seq[0] = 8'h7F; seq[1] = 8'hFF;
        play(1'b1, 8, 4);
        play(1'b0, 8, 4);

        // Random sequences, random carrier settings
        for (int b = 0; b < 10; b++) begin
            nseq = 1 + int'($urandom % 8);
            for (int k = 0; k < nseq; k++)
                seq[k] = {1'($urandom), 4'b0, 3'($urandom)};
            play(1'($urandom), 3 + int'($urandom % 10), int'($urandom % 8));
        end

        // R7 clear during a burst: the current run still completes
        rle_en = 1'b1; car_period = 8'd8; pw_code = 3'd4;
        clear_q();
        push(8'h05); push(8'h83); push(8'h02); push(8'h01);
        tx_enable = 1'b1;
        @(posedge clk);
        for (int t = 0; t <= 6 * BC + 2; t++) begin
            @(negedge clk);
            if (t == 5) fifo_clr = 1'b1;
            if (t == 6) begin
                fifo_clr = 1'b0;
                chk(fifo_count == 0, "R7 count after mid-run clear", fifo_count, 0);
            end
            if (t == 6 * BC - 1) chk(busy == 1, "R7 run completes after clear", int'(busy), 1);
            if (t == 6 * BC) chk(busy == 0, "R7 nothing follows cleared run", int'(busy), 0);
            if (t == 6 * BC + 2) chk(ir_out == 0, "R8 output low when idle", int'(ir_out), 0);
        end
        tx_enable = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule